// File: doc/BRIEF.md
# Load-Multiple Register Sequencer

This block carries out a register-range load: it fills a contiguous run of the 16-entry general register file from consecutive 32-bit words in storage. The caller supplies a first register number, a last register number and a starting byte address that has already been formed from a base register plus a displacement, and pulses `start_i`. The sequencer then reads one word at a time over a request/ready/response port. It writes each returned word into the next register in ascending order until the last register has been written, and then pulses `done_o`.

The number of words is the distance from the first register to the last register plus one, taken modulo 16. When the last register number is below the first, the register index wraps from 15 to 0. The word address steps by 4 bytes for each word. A mode input chooses whether addresses are kept to 24 bits or to 31 bits, and the address wraps inside that width.

Top module: `lm_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After that edge `busy_o`, `done_o`, `rd_req_o` and `rf_we_o` are all 0.
- R2: A `start_i` seen in idle captures `first_reg_i`, `last_reg_i`, `base_addr_i` and `wide_i` at that edge. On the next cycle `rd_req_o` is 1. Later changes on those inputs have no effect on the operation.
- R3: The writes go to registers first, first+1, … in ascending order, modulo 16, and end at the last register. The number of writes is ((last − first) mod 16) + 1, so when last < first the index wraps from 15 to 0.
- R4: When the first and last register numbers are equal, exactly one word is read and written.
- R5: The first read address is `base_addr_i` masked to the active width: bits 23:0 when `wide_i`=0, bits 30:0 when `wide_i`=1. Each later address is the previous one plus 4, masked to the same width.
- R6: `rd_req_o` stays high with a stable `rd_addr_o` until `rd_ready_i` is seen. After the accept it stays low until the response has arrived, so at most one read is ever outstanding.
- R7: `rf_we_o` is 1 only in the cycle in which `rd_valid_i` returns data for the outstanding read. In that cycle `rf_wdata_o` equals `rd_data_i` and `rf_waddr_o` is the current register. A `rd_valid_i` with no outstanding read writes nothing.
- R8: `done_o` is 1 for exactly one cycle, in the cycle after the last register write. `busy_o` is 0 from the following cycle.
- R9: A `start_i` that arrives while `busy_o` is 1 is ignored, and the running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse |
| first_reg_i | input | 4 | First register to load |
| last_reg_i | input | 4 | Last register to load (inclusive) |
| base_addr_i | input | 32 | Starting byte address |
| wide_i | input | 1 | 1: 31-bit addresses, 0: 24-bit addresses |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 32 | Read byte address |
| rd_ready_i | input | 1 | Read request accepted |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |

## Verification
The hardest cases to reach are the two wraps. One is the register index crossing from 15 to 0 partway through a transfer. The other is the address rolling over the top of the 24-bit or 31-bit space in the same run. The bench sweeps all 256 first/last pairs, and it places some starting addresses just below each width limit so that both wraps happen inside real transfers. Busy-time start pulses and unsolicited `rd_valid_i` pulses are injected during the ready-wait phases.

// File: rtl/lm_pkg.sv
// Shared types for the load-multiple sequencer.
// Assumes a single-outstanding read port and a power-of-two register file.
package lm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } lm_state_e;
endpackage

// File: rtl/lm_regwalk.sv
// Register index walker: holds the current destination register and the
// number of words still to load after the current one.
// Assumes load_i and adv_i are never high together.
module lm_regwalk #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [IDX_W-1:0] first_i,
    input  logic [IDX_W-1:0] last_i,
    input  logic             adv_i,
    output logic [IDX_W-1:0] cur_o,
    output logic             last_word_o
);
    logic [IDX_W-1:0] cur_q;
    logic [IDX_W-1:0] left_q;
    logic [IDX_W-1:0] end_q;

    // Track the current register and the words remaining after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            left_q <= '0;
            end_q  <= '0;
        end else if (load_i) begin
            cur_q  <= first_i;
            left_q <= last_i - first_i;
            end_q  <= last_i;
        end else if (adv_i && left_q != '0) begin
            cur_q  <= cur_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    assign cur_o       = cur_q;
    assign last_word_o = (left_q == '0);

    // R3
    end_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_word_o |-> (cur_o == end_q));
    // R4
    single_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && first_i == last_i) |=> last_word_o);
endmodule

// File: rtl/lm_addrgen.sv
// Word address generator: captures the start address masked to the chosen
// width, then steps by one word per advance, wrapping within that width.
// Assumes NARROW_W < WIDE_W <= ADDR_W <= 64.
module lm_addrgen #(
    parameter int ADDR_W     = 32,
    parameter int NARROW_W   = 24,
    parameter int WIDE_W     = 31,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              wide_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] NARROW_MASK = ADDR_W'((64'd1 << NARROW_W) - 64'd1);
    localparam logic [ADDR_W-1:0] WIDE_MASK   = ADDR_W'((64'd1 << WIDE_W) - 64'd1);
    localparam logic [ADDR_W-1:0] STEP        = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] mask_q;
    logic [ADDR_W-1:0] load_mask;

    // Pick the address mask for the requested mode.
    always_comb load_mask = wide_i ? WIDE_MASK : NARROW_MASK;

    // Hold the current address and step it per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= NARROW_MASK;
        end else if (load_i) begin
            addr_q <= base_i & load_mask;
            mask_q <= load_mask;
        end else if (adv_i) begin
            addr_q <= (addr_q + STEP) & mask_q;
        end
    end

    assign addr_o = addr_q;

    // R5
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_o & ~WIDE_MASK) == '0);
    // R5
    word_align_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> (addr_o[1:0] == $past(addr_o[1:0])));
endmodule

// File: rtl/lm_ctrl.sv
// Control state machine: idle, issue request, wait for data, signal done.
// Assumes the responder returns exactly one rd_valid per accepted request.
module lm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic rd_ready_i,
    input  logic rd_valid_i,
    input  logic last_word_i,
    output logic load_o,
    output logic adv_o,
    output logic rd_req_o,
    output logic we_o,
    output logic busy_o,
    output logic done_o
);
    import lm_pkg::*;

    lm_state_e state_q, state_d;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)    state_d = ST_REQ;
            ST_REQ:  if (rd_ready_i) state_d = ST_WAIT;
            ST_WAIT: if (rd_valid_i) state_d = last_word_i ? ST_DONE : ST_REQ;
            ST_DONE:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        load_o   = (state_q == ST_IDLE) && start_i;
        we_o     = (state_q == ST_WAIT) && rd_valid_i;
        adv_o    = we_o;
        rd_req_o = (state_q == ST_REQ);
        busy_o   = (state_q != ST_IDLE);
        done_o   = (state_q == ST_DONE);
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);
    // R8
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o && last_word_i |=> done_o);
    // R6
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ready_i) |=> !rd_req_o);
    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |-> !load_o);
endmodule

// File: rtl/lm_sequencer.sv
// Top of the load-multiple sequencer: loads registers first..last (mod 16)
// from consecutive words starting at a pre-formed byte address.
// Assumes the read port accepts via rd_ready_i and answers via rd_valid_i.
module lm_sequencer #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int IDX_W      = 4,
    parameter int NARROW_W   = 24,
    parameter int WIDE_W     = 31,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  first_reg_i,
    input  logic [IDX_W-1:0]  last_reg_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic              wide_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ready_i,
    input  logic              rd_valid_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              rf_we_o,
    output logic [IDX_W-1:0]  rf_waddr_o,
    output logic [DATA_W-1:0] rf_wdata_o
);
    logic load, adv, last_word;

    lm_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .rd_ready_i  (rd_ready_i),
        .rd_valid_i  (rd_valid_i),
        .last_word_i (last_word),
        .load_o      (load),
        .adv_o       (adv),
        .rd_req_o    (rd_req_o),
        .we_o        (rf_we_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    lm_regwalk #(.IDX_W(IDX_W)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .first_i     (first_reg_i),
        .last_i      (last_reg_i),
        .adv_i       (adv),
        .cur_o       (rf_waddr_o),
        .last_word_o (last_word)
    );

    lm_addrgen #(
        .ADDR_W     (ADDR_W),
        .NARROW_W   (NARROW_W),
        .WIDE_W     (WIDE_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .wide_i (wide_i),
        .base_i (base_addr_i),
        .adv_i  (adv),
        .addr_o (rd_addr_o)
    );

    // Returned data goes straight to the register file.
    assign rf_wdata_o = rd_data_i;

    // R7
    write_on_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> rd_valid_i && busy_o && !rd_req_o);
    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ready_i) |=> rd_req_o && $stable(rd_addr_o));
endmodule

// File: tb/test_lm_sequencer.sv
module test_lm_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  first_reg_i = '0;
    logic [3:0]  last_reg_i = '0;
    logic [31:0] base_addr_i = '0;
    logic        wide_i = 1'b0;
    logic        busy_o, done_o, rd_req_o, rf_we_o;
    logic [31:0] rd_addr_o, rf_wdata_o;
    logic        rd_ready_i = 1'b0;
    logic        rd_valid_i = 1'b0;
    logic [31:0] rd_data_i = '0;
    logic [3:0]  rf_waddr_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    lm_sequencer i_lm_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .first_reg_i(first_reg_i), .last_reg_i(last_reg_i),
        .base_addr_i(base_addr_i), .wide_i(wide_i),
        .busy_o(busy_o), .done_o(done_o),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ready_i(rd_ready_i), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    task automatic run_op(input int f, input int l, input logic [31:0] base,
                          input bit wide, input int pat);
        int n = ((l - f) & 15) + 1;
        logic [31:0] mask = wide ? 32'h7FFF_FFFF : 32'h00FF_FFFF;
        logic [31:0] addr = base & mask;
        @(negedge clk);
        first_reg_i = 4'(f); last_reg_i = 4'(l);
        base_addr_i = base; wide_i = wide; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R2: scramble inputs after capture
        first_reg_i = 4'(f + 7); last_reg_i = 4'(l + 3);
        base_addr_i = ~base; wide_i = ~wide;
        for (int k = 0; k < n; k++) begin
            chk(rd_req_o == 1'b1, "R2", "request raised", 32'(rd_req_o), 32'd1);
            chk(rd_addr_o == addr, "R5", "read address", rd_addr_o, addr);
            for (int d = 0; d < (pat + k) % 3; d++) begin
                if (pat % 4 == 1) start_i = 1'b1;          // R9 busy start
                if (pat % 2 == 0) rd_valid_i = 1'b1;       // R7 stray valid
                #1;
                chk(rf_we_o == 1'b0, "R7", "no write without read", 32'(rf_we_o), 32'd0);
                @(negedge clk);
                start_i = 1'b0; rd_valid_i = 1'b0;
                chk(rd_req_o == 1'b1 && rd_addr_o == addr, "R6", "request held",
                    rd_addr_o, addr);
            end
            rd_ready_i = 1'b1;
            @(negedge clk);
            rd_ready_i = 1'b0;
            chk(rd_req_o == 1'b0, "R6", "no second request", 32'(rd_req_o), 32'd0);
            for (int d = 0; d < (pat + 2 * k) % 3; d++) begin
                if (pat % 4 == 3) start_i = 1'b1;          // R9 busy start
                @(negedge clk);
                start_i = 1'b0;
                chk(rd_req_o == 1'b0 && rf_we_o == 1'b0, "R6", "idle while waiting",
                    32'(rd_req_o), 32'd0);
            end
            rd_valid_i = 1'b1; rd_data_i = mem_word(addr);
            #1;
            chk(rf_we_o == 1'b1, "R7", "write on data", 32'(rf_we_o), 32'd1);
            chk(rf_waddr_o == 4'((f + k) & 15), "R3", "write register",
                32'(rf_waddr_o), 32'((f + k) & 15));
            chk(rf_wdata_o == mem_word(addr), "R7", "write data", rf_wdata_o, mem_word(addr));
            @(negedge clk);
            rd_valid_i = 1'b0;
            addr = (addr + 32'd4) & mask;
            if (k < n - 1)
                chk(done_o == 1'b0, "R3", "no early finish", 32'(done_o), 32'd0);
        end
        chk(done_o == 1'b1 && rd_req_o == 1'b0, (n == 1) ? "R4" : "R8", "done after last write",
            32'(done_o), 32'd1);
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, "R8", "done single cycle",
            {busy_o, done_o}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] bases [4];
        bases[0] = 32'h0000_1000;
        bases[1] = 32'hFF00_0010;
        bases[2] = 32'h00FF_FFF0;
        bases[3] = 32'h7FFF_FFF8;
        repeat (3) @(negedge clk);
        // R1
        chk({busy_o, done_o, rd_req_o, rf_we_o} == 4'b0, "R1", "reset outputs",
            32'({busy_o, done_o, rd_req_o, rf_we_o}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1", "idle after reset", 32'(busy_o), 32'd0);
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                run_op(i, j, bases[(i + j) % 4], ((i ^ j) & 1) == 1, i + 3 * j);
        // R4 plain single-word case at the top register
        run_op(15, 15, 32'h00FF_FFFC, 1'b0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule